// File: doc/BRIEF.md
# Receive Status Capture and Interrupt Register

This block gathers one-cycle event pulses from a packet receive path into an 8-bit status byte. Each bit latches on its event and holds until the host reads the byte. The read strobe clears every bit one cycle later, unless a new event arrives in that same cycle. The host then finds the byte ready for the status of the next packet.

A single interrupt line summarises the captured bits. Four error bits always take part in the interrupt. The dribble bit and the new-status bit never do. The bad-packet bit and the header-received bit take part only when their own enable is set, and both enables are off after reset. A global disable input holds the interrupt low no matter what the bits or enables are. The interrupt is combinational from the held bits and the enable inputs, so a change to an enable shows on the line in the same cycle.

Top module: `rx_status_irq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls with no events, `status` is 8'h00 and `irq` is 0.
- R2: A pulse on an event input sets its bit at the next clock edge. The bit positions are: overflow 0, CRC error 1, dribble 2, undersize 3, oversize 4, bad packet 5, header received 6, new status 7.
- R3: With `rd_stb` low, a set bit stays set on every later edge.
- R4: An edge with `rd_stb` high clears every bit that has no event pulse in that same cycle.
- R5: An event pulse in the same cycle as `rd_stb` leaves its bit set after the edge, so the event is not lost.
- R6: Bits 0, 1, 3 and 4 each drive `irq` high while set, when `rx_irq_dis` is low.
- R7: Bits 2 and 7 never drive `irq`.
- R8: Bit 5 drives `irq` only while `en_bad_irq` is high. Bit 6 drives `irq` only while `en_hdr_irq` is high.
- R9: While `rx_irq_dis` is high, `irq` is 0.
- R10: `irq` follows the enable and disable inputs in the same cycle. It falls in the cycle after a clearing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_fifo_ovf | input | 1 | Receive FIFO overflow event |
| ev_crc_err | input | 1 | CRC error event |
| ev_undersize | input | 1 | Undersize packet event |
| ev_oversize | input | 1 | Oversize packet event |
| ev_dribble | input | 1 | Dribble error event |
| ev_pkt_bad | input | 1 | Packet-had-error event |
| ev_hdr_rcvd | input | 1 | Header (first 12 bytes) received event |
| ev_new_stat | input | 1 | New packet status event |
| rd_stb | input | 1 | Host read of the status byte; clears it at the edge |
| en_bad_irq | input | 1 | Lets bit 5 drive the interrupt |
| en_hdr_irq | input | 1 | Lets bit 6 drive the interrupt |
| rx_irq_dis | input | 1 | Global receive interrupt disable |
| status | output | 8 | Held status byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench first pulses each event on its own and then reads. This shows that every bit lands at its own position and that only the interrupt-capable bits raise the line. It then builds up several events without a read, to separate holding from clearing. It places events in the same cycle as a read, which tells apart a design where the event wins from one where the read wins. It toggles the two enables and the global disable while bits are held, which shows that the interrupt follows those inputs in the same cycle. A long stretch of random pulses, reads and enables is then compared cycle by cycle against a behavioural model.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int STAT_W = 8;

    typedef struct packed {
        logic new_stat;   // 7
        logic hdr_rcvd;   // 6
        logic pkt_bad;    // 5
        logic oversize;   // 4
        logic undersize;  // 3
        logic dribble;    // 2
        logic crc_err;    // 1
        logic fifo_ovf;   // 0
    } rx_evt_t;

    localparam logic [STAT_W-1:0] ALWAYS_IRQ = 8'b0001_1011;
    localparam logic [STAT_W-1:0] BAD_BIT    = 8'b0010_0000;
    localparam logic [STAT_W-1:0] HDR_BIT    = 8'b0100_0000;

    function automatic logic [STAT_W-1:0] irq_cap(input logic en_bad, input logic en_hdr);
        return ALWAYS_IRQ | (en_bad ? BAD_BIT : '0) | (en_hdr ? HDR_BIT : '0);
    endfunction
endpackage

// File: rtl/rxs_sticky_bit.sv
module rxs_sticky_bit (
    input  logic clk,
    input  logic rst,
    input  logic ev,
    input  logic rd,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= (q & ~rd) | ev;
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (rst) ev |=> q);
    assert_clear_R4: assert property (@(posedge clk) disable iff (rst) (rd && !ev) |=> !q);
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst) (q && !rd) |=> q);
    assert_idle_R3: assert property (@(posedge clk) disable iff (rst) (!q && !ev) |=> !q);
endmodule

// File: rtl/rxs_irq_mask.sv
module rxs_irq_mask
    import rxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] st,
    input  logic              en_bad,
    input  logic              en_hdr,
    input  logic              dis,
    output logic              irq
);
    logic [STAT_W-1:0] cap;
    always_comb begin
        cap = irq_cap(en_bad, en_hdr);
        irq = !dis && |(st & cap);
    end

    assert_dis_R9: assert property (@(posedge clk) disable iff (rst) dis |-> !irq);
    assert_never_R7: assert property (@(posedge clk) disable iff (rst)
        ((st & 8'b0111_1011) == '0) |-> !irq);
    assert_bad_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (!en_bad && (st & 8'b0101_1011) == '0) |-> !irq);
    assert_hdr_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (!en_hdr && (st & 8'b0011_1011) == '0) |-> !irq);
    assert_err_R6: assert property (@(posedge clk) disable iff (rst)
        (!dis && (st & 8'b0001_1011) != '0) |-> irq);
endmodule

// File: rtl/rx_status_irq.sv
module rx_status_irq
    import rxs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ev_fifo_ovf,
    input  logic       ev_crc_err,
    input  logic       ev_undersize,
    input  logic       ev_oversize,
    input  logic       ev_dribble,
    input  logic       ev_pkt_bad,
    input  logic       ev_hdr_rcvd,
    input  logic       ev_new_stat,
    input  logic       rd_stb,
    input  logic       en_bad_irq,
    input  logic       en_hdr_irq,
    input  logic       rx_irq_dis,
    output logic [7:0] status,
    output logic       irq
);
    rx_evt_t           evt;
    logic [STAT_W-1:0] evt_v;
    logic [STAT_W-1:0] st_q;

    always_comb begin
        evt.fifo_ovf  = ev_fifo_ovf;
        evt.crc_err   = ev_crc_err;
        evt.dribble   = ev_dribble;
        evt.undersize = ev_undersize;
        evt.oversize  = ev_oversize;
        evt.pkt_bad   = ev_pkt_bad;
        evt.hdr_rcvd  = ev_hdr_rcvd;
        evt.new_stat  = ev_new_stat;
        evt_v         = evt;
    end

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        rxs_sticky_bit u_bit (
            .clk (clk),
            .rst (rst),
            .ev  (evt_v[i]),
            .rd  (rd_stb),
            .q   (st_q[i])
        );
    end

    rxs_irq_mask u_mask (
        .clk    (clk),
        .rst    (rst),
        .st     (st_q),
        .en_bad (en_bad_irq),
        .en_hdr (en_hdr_irq),
        .dis    (rx_irq_dis),
        .irq    (irq)
    );

    assign status = st_q;

    assert_reset_R1: assert property (@(posedge clk) rst |=> (status == 8'h00));
    assert_irqfall_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && evt_v == '0) |=> !irq);
endmodule

// File: tb/rx_status_irq_bench.sv
`timescale 1ns/1ps
module rx_status_irq_bench;
    logic clk = 1'b0;
    logic rst;
    logic [7:0] ev;
    logic rd, en_bad, en_hdr, dis;
    logic [7:0] status;
    logic irq;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_st;
    bit done = 0;

    always #2.5 clk = ~clk;

    rx_status_irq u_rx_status_irq (
        .clk(clk), .rst(rst),
        .ev_fifo_ovf(ev[0]), .ev_crc_err(ev[1]), .ev_dribble(ev[2]),
        .ev_undersize(ev[3]), .ev_oversize(ev[4]), .ev_pkt_bad(ev[5]),
        .ev_hdr_rcvd(ev[6]), .ev_new_stat(ev[7]),
        .rd_stb(rd), .en_bad_irq(en_bad), .en_hdr_irq(en_hdr),
        .rx_irq_dis(dis), .status(status), .irq(irq)
    );

    function automatic logic model_irq();
        logic r = 1'b0;
        for (int i = 0; i < 8; i++) begin
            bit ok = (i == 0) || (i == 1) || (i == 3) || (i == 4) ||
                     (i == 5 && en_bad) || (i == 6 && en_hdr);
            if (m_st[i] && ok) r = 1'b1;
        end
        return r && !dis;
    endfunction

    task automatic compare(string tag);
        logic exp_irq = model_irq();
        checks++;
        if (status !== m_st) begin
            fails++;
            $display("FAIL %s status actual=%h expected=%h", tag, status, m_st);
        end
        checks++;
        if (irq !== exp_irq) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp_irq);
        end
    endtask

    // One cycle: drive at negedge, check just after, then advance the model at posedge.
    task automatic cyc(logic [7:0] e, logic r, logic eb, logic eh, logic d, string tag);
        @(negedge clk);
        ev = e; rd = r; en_bad = eb; en_hdr = eh; dis = d;
        #1 compare(tag);
        @(posedge clk);
        if (rst) m_st = 8'h00;
        else     m_st = (r ? 8'h00 : m_st) | e;
    endtask

    initial begin
        #(5 * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ev = '0; rd = 0; en_bad = 0; en_hdr = 0; dis = 0;
        m_st = 8'h00;
        repeat (3) cyc(8'h00, 0, 0, 0, 0, "R1");
        rst = 1'b0;
        cyc(8'h00, 0, 0, 0, 0, "R1");
        cyc(8'h00, 0, 0, 0, 0, "R1");

        // R2 R6 R7: each event alone, then a clearing read
        for (int i = 0; i < 8; i++) begin
            cyc(8'(1 << i), 0, 0, 0, 0, "R2");
            cyc(8'h00, 0, 0, 0, 0, (i == 2 || i == 7) ? "R7" : "R6");
            cyc(8'h00, 1, 0, 0, 0, "R4");
            cyc(8'h00, 0, 0, 0, 0, "R10");
        end

        // R3: accumulate without reading
        cyc(8'h04, 0, 0, 0, 0, "R3");
        cyc(8'h80, 0, 0, 0, 0, "R3");
        cyc(8'h00, 0, 0, 0, 0, "R3");
        cyc(8'h10, 0, 0, 0, 0, "R3");
        repeat (3) cyc(8'h00, 0, 0, 0, 0, "R3");

        // R5: event in the read cycle survives
        cyc(8'h02, 1, 0, 0, 0, "R5");
        cyc(8'h00, 0, 0, 0, 0, "R5");
        cyc(8'h00, 1, 0, 0, 0, "R4");
        cyc(8'h00, 0, 0, 0, 0, "R4");

        // R8 R10: gated bits follow enables in the same cycle
        cyc(8'h60, 0, 0, 0, 0, "R8");
        cyc(8'h00, 0, 0, 0, 0, "R8");
        cyc(8'h00, 0, 1, 0, 0, "R10");
        cyc(8'h00, 0, 0, 1, 0, "R10");
        cyc(8'h00, 0, 1, 1, 0, "R8");
        // R9: global disable overrides
        cyc(8'h1B, 0, 1, 1, 1, "R9");
        cyc(8'h00, 0, 1, 1, 1, "R9");
        cyc(8'h00, 0, 1, 1, 0, "R10");
        cyc(8'h00, 1, 1, 1, 0, "R4");
        cyc(8'h00, 0, 1, 1, 0, "R10");

        // Random mix against the model
        for (int n = 0; n < 400; n++) begin
            logic [7:0] e = 8'($urandom) & 8'($urandom);
            cyc(e, ($urandom % 4) == 0, 1'($urandom), 1'($urandom),
                ($urandom % 5) == 0, "R3");
        end
        cyc(8'h00, 0, 0, 0, 0, "R3");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule